// File: doc/BRIEF.md
# Dual-Law Serial Bit Clock Generator

This block makes the serial bit clock of a serial-peripheral master from a faster module clock. A configuration word, held steady by the surrounding logic, carries two divide fields and a law-select bit. When the select bit is set, the bit clock period is 2*(n+1) module clocks, where n is the 8-bit linear field. When it is clear, the period is 2^(n+1) module clocks, where n is the 4-bit exponent field. Each half of the period lasts the same number of cycles, so the duty cycle is 50%.

The block drives the bit clock as a registered level. It also drives two single-cycle strobes, one with each rising and one with each falling transition, so that shift logic on the module clock can act on bit-clock edges without a second clock domain. A change to the configuration word is taken up only when the bit clock next toggles, so that no half period is ever cut short. While the enable input is low, the divider rests with the bit clock low. Software picks the field values that give a wanted frequency.

Top module: `spi_bitclk_gen`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `sclk_o`, `rise_o` and `fall_o` are 0.
- R2: With `cfg_i[12]` = 1 (linear law), `sclk_o` holds each level for exactly `cfg_i[7:0]`+1 module clocks. `cfg_i[7:0]` = 255 gives 256.
- R3: With `cfg_i[12]` = 0 (power-of-two law), `sclk_o` holds each level for exactly 2^`cfg_i[11:8]` module clocks. `cfg_i[11:8]` = 0 gives 1.
- R4: The linear setting `cfg_i[7:0]` = 0 toggles `sclk_o` on every module clock, which is half the module clock rate.
- R5: A new value on `cfg_i` is used only from the next toggle of `sclk_o` onward. The half period already running completes with the length that was in force when it began.
- R6: While `en_i` is 0, `sclk_o` is 0 and no strobe fires. Dropping `en_i` forces `sclk_o` low with no strobe. After `en_i` rises, the first rising transition of `sclk_o` comes after exactly one half period of the current setting.
- R7: `rise_o` is 1 for one cycle, in the same cycle that `sclk_o` first reads 1 after a toggle. `fall_o` does the same when `sclk_o` first reads 0 after a toggle. The two strobes are never 1 together.
- R8: The field that the selected law does not use (`cfg_i[11:8]` under the linear law, `cfg_i[7:0]` under the power-of-two law) has no effect on `sclk_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Divider run enable |
| cfg_i | input | 13 | Divide word: [7:0] linear field, [11:8] exponent field, [12] law select (1 = linear) |
| sclk_o | output | 1 | Bit clock, 50% duty, idles low |
| rise_o | output | 1 | One-cycle strobe with each rising transition of `sclk_o` |
| fall_o | output | 1 | One-cycle strobe with each falling transition of `sclk_o` |

## Verification
A counter that wraps at the wrong count, or a latched half period taken from the wrong field, shows on `sclk_o` at the first toggle after the fault. That toggle comes at most one half period later, which is 32768 module clocks for the slowest setting and a single clock for the fastest. A setting taken up in the middle of a half period shows as one shortened or stretched level right after the change. A strobe out of step with the level it announces shows in the same cycle, because the bench compares every output against its reference model on every clock.

// File: rtl/spi_bclk_pkg.sv
package spi_bclk_pkg;

  // Divide law chosen by the select bit of the configuration word
  typedef enum logic {
    LAW_POW2   = 1'b0,
    LAW_LINEAR = 1'b1
  } bclk_law_e;

endpackage

// File: rtl/bclk_law_decode.sv
module bclk_law_decode
  import spi_bclk_pkg::*;
#(
  parameter int LIN_W  = 8,
  parameter int EXP_W  = 4,
  parameter int HALF_W = 16,
  localparam int SEL_BIT = LIN_W + EXP_W,
  localparam int CFG_W   = SEL_BIT + 1
) (
  input  logic [CFG_W-1:0]  cfg,
  output logic [HALF_W-1:0] half_len
);

  bclk_law_e         law;
  logic [LIN_W-1:0]  lin_n;
  logic [EXP_W-1:0]  exp_n;
  logic [HALF_W-1:0] lin_half;
  logic [HALF_W-1:0] pow_half;

  assign law   = bclk_law_e'(cfg[SEL_BIT]);
  assign lin_n = cfg[LIN_W-1:0];
  assign exp_n = cfg[SEL_BIT-1:LIN_W];

  // Half period in module clocks: n+1 for linear, 2^n for power of two
  assign lin_half = HALF_W'(lin_n) + HALF_W'(1);
  assign pow_half = HALF_W'(1) << exp_n;

  always_comb begin
    unique case (law)
      LAW_LINEAR: half_len = lin_half;
      default:    half_len = pow_half;
    endcase
  end

  always_comb begin
    assert_half_nonzero_R2: assert (half_len != '0);
  end

endmodule

// File: rtl/bclk_phase_counter.sv
module bclk_phase_counter #(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [HALF_W-1:0] half_in,
  output logic              tick
);

  logic [HALF_W-1:0] cnt_q;
  logic [HALF_W-1:0] half_q;

  // Last cycle of the current half period
  assign tick = run && (cnt_q == half_q - HALF_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q  <= '0;
      half_q <= half_in;
    end else if (tick) begin
      cnt_q  <= '0;
      half_q <= half_in;   // new setting taken only at a boundary
    end else begin
      cnt_q  <= cnt_q + HALF_W'(1);
    end
  end

  // R5: the latched length holds for the whole half period
  assert_len_held_R5: assert property (@(posedge clk) disable iff (rst)
    (run && !tick) |=> (half_q == $past(half_q)));

  // R2: the count stays inside the latched half period
  assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (rst)
    cnt_q < half_q);

  // R6: a stopped divider restarts its count from zero
  assert_idle_clear_R6: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt_q == '0));

endmodule

// File: rtl/bclk_edge_out.sv
module bclk_edge_out (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  output logic sclk,
  output logic rise,
  output logic fall
);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      sclk <= 1'b0;
      rise <= 1'b0;
      fall <= 1'b0;
    end else begin
      rise <= tick && !sclk;
      fall <= tick && sclk;
      if (tick) sclk <= !sclk;
    end
  end

  // R7: strobes are exclusive and agree with the level they announce
  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rise, fall}));

  assert_rise_level_R7: assert property (@(posedge clk) disable iff (rst)
    rise |-> sclk);

  assert_fall_level_R7: assert property (@(posedge clk) disable iff (rst)
    fall |-> !sclk);

  // R6: a stopped divider leaves the bit clock low
  assert_idle_low_R6: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!sclk && !rise && !fall));

endmodule

// File: rtl/spi_bitclk_gen.sv
module spi_bitclk_gen #(
  parameter int LIN_W = 8,
  parameter int EXP_W = 4,
  localparam int SEL_BIT = LIN_W + EXP_W,
  localparam int CFG_W   = SEL_BIT + 1,
  localparam int HALF_W  = ((LIN_W + 1) > (1 << EXP_W)) ? (LIN_W + 1) : (1 << EXP_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             sclk_o,
  output logic             rise_o,
  output logic             fall_o
);

  logic [HALF_W-1:0] half_len;
  logic              tick;

  bclk_law_decode #(
    .LIN_W (LIN_W),
    .EXP_W (EXP_W),
    .HALF_W(HALF_W)
  ) u_decode (
    .cfg     (cfg_i),
    .half_len(half_len)
  );

  bclk_phase_counter #(
    .HALF_W(HALF_W)
  ) u_counter (
    .clk    (clk),
    .rst    (rst),
    .run    (en_i),
    .half_in(half_len),
    .tick   (tick)
  );

  bclk_edge_out u_edge (
    .clk (clk),
    .rst (rst),
    .run (en_i),
    .tick(tick),
    .sclk(sclk_o),
    .rise(rise_o),
    .fall(fall_o)
  );

  // R1: outputs quiet right after reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!sclk_o && !rise_o && !fall_o));

  // R7: while running, every level change carries its strobe
  assert_change_strobed_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(en_i) && en_i && (sclk_o != $past(sclk_o))) |-> (rise_o || fall_o));

endmodule

// File: tb/test_spi_bitclk_gen.sv
module test_spi_bitclk_gen;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en_i = 1'b0;
  logic [12:0] cfg_i = 13'h1000;
  logic        sclk_o, rise_o, fall_o;

  int total = 0;
  int bad   = 0;
  bit cmp_on = 1'b0;
  string tag = "R1";

  always #4 clk = ~clk;   // 125 MHz

  spi_bitclk_gen i_spi_bitclk_gen (
    .clk   (clk),
    .rst   (rst),
    .en_i  (en_i),
    .cfg_i (cfg_i),
    .sclk_o(sclk_o),
    .rise_o(rise_o),
    .fall_o(fall_o)
  );

  function automatic int half_of(input logic [12:0] c);
    if (c[12]) return int'(c[7:0]) + 1;
    return 1 << c[11:8];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  // Behavioural reference, advanced on every clock
  int m_cnt = 0;
  int m_half = 1;
  bit m_sclk = 0, m_rise = 0, m_fall = 0;

  always @(posedge clk) begin
    m_rise = 0;
    m_fall = 0;
    if (rst || !en_i) begin
      m_cnt  = 0;
      m_sclk = 0;
      m_half = half_of(cfg_i);
    end else begin
      m_cnt++;
      if (m_cnt >= m_half) begin
        m_sclk = !m_sclk;
        m_rise = m_sclk;
        m_fall = !m_sclk;
        m_cnt  = 0;
        m_half = half_of(cfg_i);
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(sclk_o === m_sclk, {tag, " sclk"}, int'(sclk_o), int'(m_sclk));
      chk(rise_o === m_rise, {tag, " rise R7"}, int'(rise_o), int'(m_rise));
      chk(fall_o === m_fall, {tag, " fall R7"}, int'(fall_o), int'(m_fall));
    end
  end

  task automatic sync_rise();
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (rise_o !== 1'b1 && guard < 70000);
  endtask

  // Count cycles from the current negedge to the next strobe
  task automatic gap_to_next(input int expv, input string req);
    int c = 0;
    do begin
      @(negedge clk);
      c++;
    end while (rise_o !== 1'b1 && fall_o !== 1'b1 && c < 70000);
    chk(c == expv, req, c, expv);
  endtask

  task automatic measure(input logic [12:0] c, input int expv, input string req);
    @(negedge clk);
    tag   = req;
    cfg_i = c;
    sync_rise();
    sync_rise();        // first full half period under the new setting
    gap_to_next(expv, req);
    gap_to_next(expv, req);
  endtask

  initial begin
    #(8 * 190000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: quiet during reset
    chk(sclk_o === 1'b0 && rise_o === 1'b0 && fall_o === 1'b0, "R1 in reset",
        int'({sclk_o, rise_o, fall_o}), 0);
    cmp_on = 1'b1;
    rst = 1'b0;
    @(negedge clk);
    chk(sclk_o === 1'b0 && rise_o === 1'b0 && fall_o === 1'b0, "R1 after reset",
        int'({sclk_o, rise_o, fall_o}), 0);

    // R6: disabled divider stays low
    tag   = "R6";
    cfg_i = 13'h1004;            // linear, half = 5
    repeat (10) @(negedge clk);
    chk(sclk_o === 1'b0, "R6 idle low", int'(sclk_o), 0);
    en_i = 1'b1;
    begin
      int c = 0;
      do begin
        @(negedge clk);
        c++;
      end while (sclk_o !== 1'b1 && c < 100);
      chk(c == 5, "R6 first rise", c, 5);
    end

    // R4: fastest linear setting
    measure(13'h1000, 1, "R4");
    // R2: linear sweep, including the largest field
    measure(13'h1001, 2, "R2");
    measure(13'h1007, 8, "R2");
    measure(13'h1064, 101, "R2");
    measure(13'h10FF, 256, "R2");
    // R3: power-of-two sweep
    measure(13'h0000, 1, "R3");
    measure(13'h0100, 2, "R3");
    measure(13'h0500, 32, "R3");
    measure(13'h0C00, 4096, "R3");
    // R8: unused field ignored
    measure(13'h1F03, 4, "R8 linear");
    measure(13'h02FF, 4, "R8 pow2");

    // R5: change mid half period
    @(negedge clk);
    tag   = "R5";
    cfg_i = 13'h1009;            // half = 10
    sync_rise();
    sync_rise();
    repeat (3) @(negedge clk);
    cfg_i = 13'h1002;            // half = 3, from next toggle
    gap_to_next(7, "R5 old length kept");
    gap_to_next(3, "R5 new length used");

    // R6: dropping enable forces low with no strobe
    tag = "R6";
    sync_rise();
    en_i = 1'b0;
    @(negedge clk);
    chk(sclk_o === 1'b0 && fall_o === 1'b0, "R6 drop enable",
        int'({sclk_o, fall_o}), 0);
    repeat (5) @(negedge clk);
    chk(sclk_o === 1'b0, "R6 held low", int'(sclk_o), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule